// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block pushes a raw configuration image into a programmable device over a passive serial link. An upstream source offers the image one byte at a time over a valid/ready handshake, marking the final byte with a last flag. The loader sends nothing of its own ahead of or behind the stream. Every byte it receives becomes eight serial bits on the wire, and nothing else does.

A `start` pulse begins a load. The loader first holds the target's active-low configuration reset low for a fixed number of cycles. It then releases the reset and waits a programmed settling interval, sized to cover the target's few-microsecond recovery. Only after that does it accept bytes. It shifts each byte out least significant bit first. The generated serial clock has a 50% duty cycle, and the data line only moves while that clock is low, because the target samples on the rising edge.

During loading, the target's active-low status line is the only error signal. If it drops, the load is aborted and an error is flagged. After the last bit, the loader keeps clocking for a bounded number of serial clock periods and waits for the target's done line. If done rises, the load succeeded. If the budget runs out first, a timeout error is flagged.

Top module: `ps_cfg_loader`

## Requirements
- R1: While `rst_n` is low, `cfg_rst_n` is 1, `cfg_clk` is 0, `in_ready` is 0, and `load_busy`, `load_ok`, `err_status` and `err_timeout` are all 0.
- R2: A `start` pulse outside a load drives `cfg_rst_n` low for exactly RST_CYCLES clock cycles. A `start` pulse during a load is ignored: `cfg_rst_n` does not fall again.
- R3: `cfg_data` never changes while `cfg_clk` is high.
- R4: `cfg_clk` stays low while `cfg_rst_n` is low. The first rising edge of `cfg_clk` comes at least WAIT_CYCLES and at most WAIT_CYCLES+2*CLK_DIV+2 clock cycles after `cfg_rst_n` rises.
- R5: Each accepted byte produces exactly eight `cfg_clk` rising edges. At the k-th of these edges (k = 0..7), `cfg_data` holds bit k of the byte. Bytes go out in the order they were accepted, with no extra bits before, between or after them.
- R6: Each high phase of `cfg_clk` lasts exactly CLK_DIV cycles, and each low phase lasts at least CLK_DIV cycles.
- R7: If `cfg_done` is high after the bit of the last-flagged byte has been sent, `load_ok` is set and `cfg_clk` stops.
- R8: If `cfg_done` stays low, exactly TAIL_CLOCKS further `cfg_clk` rising edges follow the last data bit. Then `err_timeout` is set and the clock stops.
- R9: If `cfg_status_n` is low during loading or the tail wait, the load aborts. `err_status` is set, `cfg_clk` stops, `in_ready` stays low, and a later `cfg_done` is ignored (`load_ok` stays 0).
- R10: `in_ready` is high only while loading with no byte in the shifter. It is never high while `cfg_clk` is high or while `cfg_rst_n` is low.
- R11: `cfg_status_n` and `cfg_done` are ignored during the reset and settling phases. A low status there does not stop the load.
- R12: A new `start` after a completed or failed load clears the result flags and runs a full load again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse to begin a load |
| in_data | input | DATA_W | Image byte from upstream |
| in_valid | input | 1 | `in_data` is valid |
| in_last | input | 1 | This byte ends the image |
| in_ready | output | 1 | Loader takes the byte this cycle if valid |
| cfg_rst_n | output | 1 | Active-low configuration reset to the target |
| cfg_clk | output | 1 | Serial configuration clock |
| cfg_data | output | 1 | Serial configuration data bit |
| cfg_status_n | input | 1 | Active-low error status from the target |
| cfg_done | input | 1 | Configuration-complete indication from the target |
| load_busy | output | 1 | Load sequence in progress |
| load_ok | output | 1 | Last load finished with done high |
| err_status | output | 1 | Last load aborted on low status |
| err_timeout | output | 1 | Last load ended without done |

## Verification
Some properties are checked by assertions on every cycle:
- the data line is frozen while the serial clock is high;
- no clock is issued under configuration reset;
- the handshake stays quiet while a bit is on the wire;
- the link stays silent after a status abort;
- the tail counter stays within its bound.

Other behaviour can only be shown by the bench scenarios:
- the bit order and byte content, swept over all 256 byte values;
- the exact reset width and settling gap;
- the exact number of tail clocks before a timeout;
- that status and done are ignored outside loading;
- that a restart recovers cleanly.

// File: rtl/ps_cfg_pkg.sv
// Shared definitions for the passive serial configuration loader.
package ps_cfg_pkg;

    // Sequencer phases; the result states hold until the next start.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RESET     = 3'd1,
        ST_SETTLE    = 3'd2,
        ST_LOAD      = 3'd3,
        ST_TAIL      = 3'd4,
        ST_PASS      = 3'd5,
        ST_FAIL_STAT = 3'd6,
        ST_FAIL_TIME = 3'd7
    } ldr_state_t;

endpackage

// File: rtl/ps_sclk_gen.sv
// Serial clock generator.
// Produces a clock with HALF_DIV system cycles low and then HALF_DIV high,
// while run is high. fall_tick flags the system edge at which the serial
// clock returns low; that is where the data line may move.
// Assumes HALF_DIV >= 1. Dropping run forces the clock low and rewinds
// the phase counter.
module ps_sclk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic fall_tick
);
    localparam int PERIOD = 2 * HALF_DIV;
    localparam int CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] phase;
    logic [CW-1:0] phase_nxt;
    logic          wrap;

    // Phase wrap detection and next-phase value.
    always_comb begin
        wrap      = (phase == CW'(PERIOD - 1));
        phase_nxt = wrap ? '0 : phase + CW'(1);
    end

    assign fall_tick = run && wrap;

    // Phase counter and registered serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= '0;
            sclk  <= 1'b0;
        end else begin
            phase <= phase_nxt;
            sclk  <= (phase_nxt >= CW'(HALF_DIV));
        end
    end

    AST_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        fall_tick |-> sclk) else $error("fall tick while clock low"); // R6

endmodule

// File: rtl/ps_bit_shifter.sv
// Byte shifter.
// Holds one image byte and presents bit 0 on sdata. Each step shifts the
// byte right by one, so bits leave least significant first.
// Assumes load is only raised while the shifter is empty. final_bit marks
// the last bit of a byte that carried the last flag.
module ps_bit_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         load_last,
    input  logic         step,
    output logic         sdata,
    output logic         holding,
    output logic         final_bit
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  shreg;
    logic [CW-1:0] left;
    logic          last_q;

    // Load, shift and empty tracking for the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            shreg   <= '0;
            left    <= '0;
            holding <= 1'b0;
            last_q  <= 1'b0;
        end else if (load) begin
            shreg   <= load_data;
            left    <= CW'(W);
            holding <= 1'b1;
            last_q  <= load_last;
        end else if (step && holding) begin
            shreg <= shreg >> 1;
            left  <= left - CW'(1);
            if (left == CW'(1)) begin
                holding <= 1'b0;
            end
        end
    end

    assign sdata     = shreg[0];
    assign final_bit = holding && last_q && (left == CW'(1));

    AST_LOAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !holding) else $error("byte loaded over a held byte"); // R10

endmodule

// File: rtl/ps_seq_ctrl.sv
// Load sequencer.
// Steps through the phases: configuration reset, settling wait, byte
// loading, tail wait for done, and a held result. Status and done are
// only looked at in the loading and tail phases.
// Assumes fall_tick pulses once per serial clock period and final_bit
// marks the last data bit of the image.
module ps_seq_ctrl
    import ps_cfg_pkg::*;
#(
    parameter int RST_CYCLES  = 250,
    parameter int WAIT_CYCLES = 1250,
    parameter int TAIL_CLOCKS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       status_n,
    input  logic       done,
    input  logic       fall_tick,
    input  logic       final_bit,
    output ldr_state_t state
);
    localparam int M1   = (RST_CYCLES > WAIT_CYCLES) ? RST_CYCLES : WAIT_CYCLES;
    localparam int MAXV = (M1 > TAIL_CLOCKS) ? M1 : TAIL_CLOCKS;
    localparam int TW   = $clog2(MAXV + 1);

    logic [TW-1:0] tmr;

    // Phase sequencing with a shared cycle/clock timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tmr   <= '0;
        end else begin
            case (state)
                ST_RESET: begin
                    if (tmr == TW'(RST_CYCLES - 1)) begin
                        state <= ST_SETTLE;
                        tmr   <= '0;
                    end else begin
                        tmr <= tmr + TW'(1);
                    end
                end
                ST_SETTLE: begin
                    if (tmr == TW'(WAIT_CYCLES - 1)) begin
                        state <= ST_LOAD;
                        tmr   <= '0;
                    end else begin
                        tmr <= tmr + TW'(1);
                    end
                end
                ST_LOAD: begin
                    if (!status_n) begin
                        state <= ST_FAIL_STAT;
                    end else if (fall_tick && final_bit) begin
                        state <= ST_TAIL;
                        tmr   <= '0;
                    end
                end
                ST_TAIL: begin
                    if (!status_n) begin
                        state <= ST_FAIL_STAT;
                    end else if (done) begin
                        state <= ST_PASS;
                    end else if (fall_tick) begin
                        if (tmr == TW'(TAIL_CLOCKS - 1)) begin
                            state <= ST_FAIL_TIME;
                        end else begin
                            tmr <= tmr + TW'(1);
                        end
                    end
                end
                default: begin
                    if (start) begin
                        state <= ST_RESET;
                        tmr   <= '0;
                    end
                end
            endcase
        end
    end

    AST_TAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL) |-> (tmr < TW'(TAIL_CLOCKS))) else $error("tail overrun"); // R8

endmodule

// File: rtl/ps_cfg_loader.sv
// Passive serial configuration loader, top level.
// Ties together the sequencer, the serial clock generator and the byte
// shifter. The serial clock runs only while a byte is held during loading,
// or during the tail wait.
// Assumes the upstream holds in_data, in_valid and in_last stable until
// the byte is taken.
module ps_cfg_loader
    import ps_cfg_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CLK_DIV     = 2,
    parameter int RST_CYCLES  = 250,
    parameter int WAIT_CYCLES = 1250,
    parameter int TAIL_CLOCKS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              cfg_rst_n,
    output logic              cfg_clk,
    output logic              cfg_data,
    input  logic              cfg_status_n,
    input  logic              cfg_done,
    output logic              load_busy,
    output logic              load_ok,
    output logic              err_status,
    output logic              err_timeout
);
    ldr_state_t state;
    logic       holding;
    logic       final_bit;
    logic       fall_tick;
    logic       take;
    logic       run;

    // Handshake and clock enable decode from the sequencer phase.
    always_comb begin
        in_ready    = (state == ST_LOAD) && !holding;
        take        = in_valid && in_ready;
        run         = ((state == ST_LOAD) && holding) || (state == ST_TAIL);
        cfg_rst_n   = (state != ST_RESET);
        load_busy   = (state == ST_RESET) || (state == ST_SETTLE) ||
                      (state == ST_LOAD)  || (state == ST_TAIL);
        load_ok     = (state == ST_PASS);
        err_status  = (state == ST_FAIL_STAT);
        err_timeout = (state == ST_FAIL_TIME);
    end

    ps_seq_ctrl #(
        .RST_CYCLES (RST_CYCLES),
        .WAIT_CYCLES(WAIT_CYCLES),
        .TAIL_CLOCKS(TAIL_CLOCKS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .status_n (cfg_status_n),
        .done     (cfg_done),
        .fall_tick(fall_tick),
        .final_bit(final_bit),
        .state    (state)
    );

    ps_sclk_gen #(
        .HALF_DIV(CLK_DIV)
    ) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sclk     (cfg_clk),
        .fall_tick(fall_tick)
    );

    ps_bit_shifter #(
        .W(DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (state == ST_RESET),
        .load     (take),
        .load_data(in_data),
        .load_last(in_last),
        .step     (fall_tick),
        .sdata    (cfg_data),
        .holding  (holding),
        .final_bit(final_bit)
    );

    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clk |-> $stable(cfg_data)) else $error("data moved while clock high"); // R3

    AST_NO_CLK_IN_CFG_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rst_n |-> !cfg_clk) else $error("clock under config reset"); // R4

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clk |-> !in_ready) else $error("ready while bit on wire"); // R10

    AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (err_status && $past(err_status)) |-> (!cfg_clk && !in_ready))
        else $error("activity after status abort"); // R9

endmodule

// File: tb/ps_cfg_loader_bench.sv
// Self-checking bench for the passive serial configuration loader.
module ps_cfg_loader_bench;
    localparam int DIV   = 2;
    localparam int RSTC  = 4;
    localparam int WAITC = 10;
    localparam int TAILC = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       cfg_rst_n, cfg_clk, cfg_data;
    logic       cfg_status_n = 1'b1;
    logic       cfg_done = 1'b0;
    logic       load_busy, load_ok, err_status, err_timeout;

    always #2 clk = ~clk;

    ps_cfg_loader #(
        .DATA_W(8), .CLK_DIV(DIV), .RST_CYCLES(RSTC),
        .WAIT_CYCLES(WAITC), .TAIL_CLOCKS(TAILC)
    ) u_ps_cfg_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .in_data(in_data),
        .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .cfg_rst_n(cfg_rst_n), .cfg_clk(cfg_clk), .cfg_data(cfg_data),
        .cfg_status_n(cfg_status_n), .cfg_done(cfg_done),
        .load_busy(load_busy), .load_ok(load_ok),
        .err_status(err_status), .err_timeout(err_timeout)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_b [0:255];
    logic rx_bits [0:4095];
    int rise_cnt, hi_len, lo_len, rst_low_len, rst_low_meas, rst_falls;
    int rst_rise_cyc, first_rise_cyc;
    int viol_r3, viol_r4, viol_r6, viol_r10;
    logic prev_clk = 1'b0, prev_data = 1'b0, prev_rstn = 1'b1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // Target-side monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cfg_rst_n) begin
                rst_low_len++;
                if (prev_rstn) rst_falls++;
                if (cfg_clk) viol_r4++;
            end else if (!prev_rstn) begin
                rst_low_meas = rst_low_len;
                rst_low_len  = 0;
                rst_rise_cyc = cyc;
            end
            if (cfg_clk && !prev_clk) begin
                if (rise_cnt < 4096) rx_bits[rise_cnt] = cfg_data;
                if (rise_cnt == 0) first_rise_cyc = cyc;
                rise_cnt++;
                if (lo_len < DIV && !err_status) viol_r6++;
                hi_len = 1;
            end else if (cfg_clk) begin
                hi_len++;
                if (cfg_data !== prev_data) viol_r3++;
            end else if (prev_clk) begin
                if (hi_len != DIV && !err_status) viol_r6++;
                lo_len = 1;
            end else begin
                lo_len++;
            end
            if (in_ready && (cfg_clk || !cfg_rst_n)) viol_r10++;
        end
        prev_clk  = cfg_clk;
        prev_data = cfg_data;
        prev_rstn = cfg_rst_n;
    end

    task automatic clear_mon();
        rise_cnt = 0; hi_len = 0; lo_len = 1000; rst_low_len = 0;
        rst_low_meas = 0; rst_falls = 0; rst_rise_cyc = 0; first_rise_cyc = 0;
        viol_r3 = 0; viol_r4 = 0; viol_r6 = 0; viol_r10 = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic send_bytes(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            in_data  = exp_b[i][7:0];
            in_last  = (i == n - 1);
            in_valid = 1'b1;
            while (!in_ready && !err_status) @(negedge clk);
            if (err_status) begin
                in_valid = 1'b0;
                in_last  = 1'b0;
                return;
            end
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
            if (gaps) repeat (i % 3) @(negedge clk);
        end
    endtask

    task automatic wait_result();
        for (int i = 0; i < 3000; i++) begin
            if (load_ok || err_status || err_timeout) return;
            @(negedge clk);
        end
    endtask

    task automatic check_stream(input int n);
        for (int j = 0; j < n; j++) begin
            logic [7:0] got;
            for (int k = 0; k < 8; k++) got[k] = rx_bits[8 * j + k];
            check(got == exp_b[j][7:0], "R5", "byte value", got, exp_b[j]);
        end
    endtask

    task automatic check_timing();
        int gap;
        gap = first_rise_cyc - rst_rise_cyc;
        check(rst_low_meas == RSTC, "R2", "config reset width", rst_low_meas, RSTC);
        check(gap >= WAITC && gap <= WAITC + 2 * DIV + 2, "R4", "settle gap", gap, WAITC);
        check(viol_r4 == 0, "R4", "clock under reset", viol_r4, 0);
        check(viol_r3 == 0, "R3", "data change while high", viol_r3, 0);
        check(viol_r6 == 0, "R6", "duty violations", viol_r6, 0);
        check(viol_r10 == 0, "R10", "ready while busy", viol_r10, 0);
    endtask

    initial begin
        #600000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int snap;
        clear_mon();
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cfg_rst_n == 1'b1, "R1", "cfg_rst_n in reset", cfg_rst_n, 1);
        check(cfg_clk == 1'b0, "R1", "cfg_clk in reset", cfg_clk, 0);
        check(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
        check({load_busy, load_ok, err_status, err_timeout} == 4'b0, "R1", "flags in reset",
              {load_busy, load_ok, err_status, err_timeout}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Scenario A: every byte value 0..255, done after the last bit (R5, R7)
        for (int i = 0; i < 256; i++) exp_b[i] = i;
        clear_mon();
        pulse_start();
        fork
            send_bytes(256, 1'b0);
            begin
                wait (rise_cnt == 8 * 256);
                @(negedge clk) cfg_done = 1'b1;
            end
        join
        wait_result();
        check(load_ok == 1'b1, "R7", "load_ok after done", load_ok, 1);
        check(rise_cnt == 2048, "R7", "rises on success", rise_cnt, 2048);
        check_stream(256);
        check_timing();
        snap = rise_cnt;
        repeat (30) @(negedge clk);
        check(rise_cnt == snap && !cfg_clk, "R7", "clock stopped after pass", rise_cnt, snap);
        cfg_done = 1'b0;

        // Scenario B: gapped valid, status low in reset/settle, start mid-load (R11, R2, R12)
        for (int i = 0; i < 40; i++) exp_b[i] = (i * 73 + 19) & 255;
        clear_mon();
        cfg_status_n = 1'b0;
        pulse_start();
        check(load_ok == 1'b0, "R12", "load_ok cleared by restart", load_ok, 0);
        fork
            send_bytes(40, 1'b1);
            begin
                wait (cfg_rst_n == 1'b0);
                wait (cfg_rst_n == 1'b1);
                repeat (3) @(negedge clk);
                cfg_status_n = 1'b1;
            end
            begin
                wait (rise_cnt == 50);
                pulse_start();
            end
            begin
                wait (rise_cnt == 8 * 40);
                @(negedge clk) cfg_done = 1'b1;
            end
        join
        wait_result();
        check(load_ok == 1'b1, "R11", "pass despite early low status", load_ok, 1);
        check(rst_falls == 1, "R2", "start during load ignored", rst_falls, 1);
        check_stream(40);
        check_timing();
        cfg_done = 1'b0;

        // Scenario C: done never rises (R8)
        for (int i = 0; i < 5; i++) exp_b[i] = 8'hA5 ^ (i * 17);
        clear_mon();
        pulse_start();
        send_bytes(5, 1'b0);
        wait_result();
        check(err_timeout == 1'b1, "R8", "timeout flag", err_timeout, 1);
        check(load_ok == 1'b0, "R8", "no pass on timeout", load_ok, 0);
        check(rise_cnt == 40 + TAILC, "R8", "tail clock count", rise_cnt, 40 + TAILC);
        check_stream(5);
        snap = rise_cnt;
        repeat (30) @(negedge clk);
        check(rise_cnt == snap && !cfg_clk, "R8", "clock stopped after timeout", rise_cnt, snap);

        // Scenario D: status drops mid-stream, later done ignored (R9)
        for (int i = 0; i < 20; i++) exp_b[i] = 255 - i;
        clear_mon();
        pulse_start();
        fork
            send_bytes(20, 1'b0);
            begin
                wait (rise_cnt == 37);
                @(negedge clk) cfg_status_n = 1'b0;
                repeat (5) @(negedge clk);
                cfg_done = 1'b1;
            end
        join
        wait_result();
        repeat (4) @(negedge clk);
        snap = rise_cnt;
        repeat (50) @(negedge clk);
        check(err_status == 1'b1, "R9", "status abort flag", err_status, 1);
        check(load_ok == 1'b0, "R9", "done ignored after abort", load_ok, 0);
        check(err_timeout == 1'b0, "R9", "no timeout on abort", err_timeout, 0);
        check(rise_cnt == snap && !cfg_clk, "R9", "clock stopped on abort", rise_cnt, snap);
        check(in_ready == 1'b0, "R9", "ready low on abort", in_ready, 0);
        check(rise_cnt < 8 * 20, "R9", "stream cut short", rise_cnt, 8 * 20);
        cfg_done = 1'b0;
        cfg_status_n = 1'b1;

        // Scenario E: restart after an error (R12)
        for (int i = 0; i < 3; i++) exp_b[i] = 8'h3C + i;
        clear_mon();
        pulse_start();
        check(err_status == 1'b0, "R12", "error cleared by restart", err_status, 0);
        fork
            send_bytes(3, 1'b0);
            begin
                wait (rise_cnt == 24);
                @(negedge clk) cfg_done = 1'b1;
            end
        join
        wait_result();
        check(load_ok == 1'b1, "R12", "pass after restart", load_ok, 1);
        check(rise_cnt == 24, "R5", "rises for three bytes", rise_cnt, 24);
        check_stream(3);
        check_timing();
        cfg_done = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule